// File: doc/BRIEF.md
# Debug Port POST Code Capture

This block records the progress codes that a host writes to the two debug I/O addresses 0x80 and 0x81 during boot. The host side is a decoded I/O write channel: a 16-bit address, a 16-bit data word with two byte enables, and a valid/ready pair. Byte lane k of a transfer targets I/O address `hw_addr + k`. Every lane that lands on 0x80 or 0x81, and whose port is enabled, is stored in that port's byte register. Lanes that land anywhere else are dropped.

The channel never applies back-pressure. `hw_ready` is held high out of reset, so every cycle with `hw_valid` high is one complete transfer and the host never needs to stall. Data are latched on the clock edge that sees `hw_valid` high, and they read back on the controller side from the next cycle on.

The controller side is a small register bus with a 2-bit offset, a write strobe and a combinational read path:
- Offset 0 holds control.
- Offset 1 holds the byte captured for port 0x80.
- Offset 2 holds the byte captured for port 0x81.
- Offset 3 holds status.

Both ports share a single pending flag and a single interrupt line. Nothing records which port was written, so firmware reads both byte registers whenever the flag is set.

Top module: `dbgport_capture`

## Requirements
- R1: After reset, all four controller registers read 0x00, `irq` is low and `hw_ready` is high.
- R2: The control register (offset 0) is read/write and implements only three bits: bit 0 enables the interrupt, bit 3 enables capture for port 0x81, and bit 6 enables capture for port 0x80. Every other bit reads 0.
- R3: A byte that lands on a port whose enable bit is clear is ignored. That port's register keeps its value, and the byte does not set the pending flag.
- R4: A transfer to 0x80 with both byte enables set (`hw_be`=2'b11), when both ports are enabled, stores `hw_data[7:0]` in the port 0x80 register and `hw_data[15:8]` in the port 0x81 register.
- R5: A transfer to 0x80 with only `hw_be[0]` set updates only the port 0x80 register. The port 0x81 register keeps its previous value.
- R6: A transfer to 0x81 with only `hw_be[0]` set stores `hw_data[7:0]` in the port 0x81 register only, and it sets the pending flag.
- R7: Any stored byte sets the single shared pending flag, which is status bit 0 (offset 3). No other status bit exists, and every other bit reads 0.
- R8: Writing status with bit 0 = 1 clears the pending flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R9: If a stored byte and a clearing status write happen in the same cycle, the pending flag stays set.
- R10: `irq` is a level equal to the pending flag AND control bit 0, following both without waiting for a new capture.
- R11: The two port byte registers (offsets 1 and 2) are read-only. Controller writes to them do not change them.
- R12: Lane k targets address `hw_addr + k`. A lane that lands outside 0x80..0x81 stores nothing and does not set the flag (for example, lane 1 of a transfer to 0x81). A lane 1 that lands on 0x80 from address 0x7F is stored in the port 0x80 register.
- R13: A stored byte reads back from the controller bus in the cycle after the accepting clock edge, complete and never partly updated. When `hw_valid` is low, the byte registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Host write transfer valid |
| hw_ready | output | 1 | Always high; the channel never stalls |
| hw_addr | input | 16 | I/O address of byte lane 0 |
| hw_data | input | 16 | Write data; lane k in bits [8k+7:8k] |
| hw_be | input | 2 | Byte enables, one per lane |
| cb_addr | input | 2 | Controller register offset |
| cb_wr | input | 1 | Controller write strobe |
| cb_wdata | input | 8 | Controller write data |
| cb_rdata | output | 8 | Controller read data (combinational on cb_addr) |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The bench goes after four corner cases.
- A 16-bit transfer with only port 0x80 enabled. A decoder that gates the whole transfer on the 0x80 enable would wrongly overwrite port 0x81.
- A single-byte write to 0x80. A design that always writes the high lane would corrupt the port 0x81 byte.
- A clearing status write in the same cycle as a capture. A design that lets the clear win would lose an interrupt.
- Transfers whose upper lane spills to 0x82, or whose lower lane starts at 0x7F. A design that decodes only `hw_addr` would store or flag the wrong bytes.

On top of these directed cases, random mixes of enable settings, byte enables, addresses and clears are checked against a reference model after every step.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;
  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int NLANE   = 2;
  localparam int NPORT   = 2;
  localparam logic [ADDR_W-1:0] PORT_BASE = 16'h0080;

  // control register bit positions
  localparam int IE_BIT = 0;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'b0100_1001;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_P80  = 2'd1,
    RG_P81  = 2'd2,
    RG_STAT = 2'd3
  } reg_sel_e;

  // accept-enable bit for each port index
  function automatic int acc_bit(int p);
    return (p == 0) ? 6 : 3;
  endfunction
endpackage

// File: rtl/dbgport_decode.sv
module dbgport_decode
  import dbgport_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int BW  = BYTE_W,
  parameter int NL  = NLANE,
  parameter int NP  = NPORT,
  parameter logic [AW-1:0] BASE = PORT_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  input  logic [AW-1:0]     hw_addr,
  input  logic [NL*BW-1:0]  hw_data,
  input  logic [NL-1:0]     hw_be,
  input  logic [NP-1:0]     port_acc,
  output logic [NP-1:0]     port_wr,
  output logic [BW-1:0]     port_byte [NP]
);
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      port_wr[p]   = 1'b0;
      port_byte[p] = '0;
      for (int k = 0; k < NL; k++) begin
        if (hw_valid && hw_be[k] && port_acc[p] &&
            ((hw_addr + AW'(k)) == (BASE + AW'(p)))) begin
          port_wr[p]   = 1'b1;
          port_byte[p] = hw_data[k*BW +: BW];
        end
      end
    end
  end

  generate
    for (genvar gp = 0; gp < NP; gp++) begin : g_chk
      // R3
      strobe_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr[gp] |-> (port_acc[gp] && hw_valid));
    end
  endgenerate
endmodule

// File: rtl/dbgport_regs.sv
module dbgport_regs
  import dbgport_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NP = NPORT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NP-1:0]  port_wr,
  input  logic [BW-1:0]  port_byte [NP],
  input  logic [1:0]     cb_addr,
  input  logic           cb_wr,
  input  logic [BW-1:0]  cb_wdata,
  output logic [BW-1:0]  cb_rdata,
  output logic [NP-1:0]  port_acc,
  output logic           irq
);
  logic [BW-1:0] ctrl_q;
  logic [BW-1:0] data_q [NP];
  logic          pend_q;
  logic          clr_req;
  logic          cap_any;

  assign clr_req = cb_wr && (reg_sel_e'(cb_addr) == RG_STAT) && cb_wdata[0];
  assign cap_any = |port_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (cb_wr && reg_sel_e'(cb_addr) == RG_CTRL) begin
      ctrl_q <= cb_wdata & CTRL_MASK;
    end
  end

  generate
    for (genvar gp = 0; gp < NP; gp++) begin : g_port
      assign port_acc[gp] = ctrl_q[acc_bit(gp)];

      always_ff @(posedge clk) begin
        if (!rst_n)            data_q[gp] <= '0;
        else if (port_wr[gp])  data_q[gp] <= port_byte[gp];
      end

      // R13
      data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr[gp] |=> $stable(data_q[gp]));
      // R4
      data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr[gp] |=> (data_q[gp] == $past(port_byte[gp])));
    end
  endgenerate

  // capture has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (cap_any)  pend_q <= 1'b1;
    else if (clr_req)  pend_q <= 1'b0;
  end

  assign irq = pend_q & ctrl_q[IE_BIT];

  always_comb begin
    unique case (reg_sel_e'(cb_addr))
      RG_CTRL: cb_rdata = ctrl_q;
      RG_P80:  cb_rdata = data_q[0];
      RG_P81:  cb_rdata = data_q[NP-1];
      RG_STAT: cb_rdata = {{(BW-1){1'b0}}, pend_q};
      default: cb_rdata = '0;
    endcase
  end

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_any |=> pend_q);
  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_req) |=> pend_q);
  // R9
  cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_any && clr_req) |=> pend_q);
endmodule

// File: rtl/dbgport_capture.sv
module dbgport_capture
  import dbgport_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hw_valid,
  output logic                    hw_ready,
  input  logic [ADDR_W-1:0]       hw_addr,
  input  logic [NLANE*BYTE_W-1:0] hw_data,
  input  logic [NLANE-1:0]        hw_be,
  input  logic [1:0]              cb_addr,
  input  logic                    cb_wr,
  input  logic [BYTE_W-1:0]       cb_wdata,
  output logic [BYTE_W-1:0]       cb_rdata,
  output logic                    irq
);
  logic [NPORT-1:0]  port_acc;
  logic [NPORT-1:0]  port_wr;
  logic [BYTE_W-1:0] port_byte [NPORT];

  assign hw_ready = 1'b1;

  dbgport_decode #(
    .AW(ADDR_W), .BW(BYTE_W), .NL(NLANE), .NP(NPORT), .BASE(PORT_BASE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .hw_valid(hw_valid), .hw_addr(hw_addr), .hw_data(hw_data), .hw_be(hw_be),
    .port_acc(port_acc), .port_wr(port_wr), .port_byte(port_byte)
  );

  dbgport_regs #(.BW(BYTE_W), .NP(NPORT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .port_wr(port_wr), .port_byte(port_byte),
    .cb_addr(cb_addr), .cb_wr(cb_wr), .cb_wdata(cb_wdata), .cb_rdata(cb_rdata),
    .port_acc(port_acc), .irq(irq)
  );
endmodule

// File: tb/dbgport_capture_tb.sv
module dbgport_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic        hw_ready;
  logic [15:0] hw_addr = '0;
  logic [15:0] hw_data = '0;
  logic [1:0]  hw_be = '0;
  logic [1:0]  cb_addr = '0;
  logic        cb_wr = 1'b0;
  logic [7:0]  cb_wdata = '0;
  logic [7:0]  cb_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_ctrl, m_p80, m_p81;
  logic       m_pend;

  always #4 clk = ~clk;

  dbgport_capture u_dut (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_addr(hw_addr), .hw_data(hw_data), .hw_be(hw_be),
    .cb_addr(cb_addr), .cb_wr(cb_wr), .cb_wdata(cb_wdata),
    .cb_rdata(cb_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic lane_hit(logic [15:0] a, int k, logic [15:0] tgt);
    return (a + 16'(k)) == tgt;
  endfunction

  // reference model of one host transfer
  task automatic model_host(logic [15:0] a, logic [15:0] d, logic [1:0] be);
    for (int k = 0; k < 2; k++) begin
      if (be[k] && lane_hit(a, k, 16'h0080) && m_ctrl[6]) begin
        m_p80 = d[k*8 +: 8]; m_pend = 1'b1;
      end
      if (be[k] && lane_hit(a, k, 16'h0081) && m_ctrl[3]) begin
        m_p81 = d[k*8 +: 8]; m_pend = 1'b1;
      end
    end
  endtask

  task automatic host_wr(logic [15:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    hw_valid = 1'b1; hw_addr = a; hw_data = d; hw_be = be;
    @(negedge clk);
    hw_valid = 1'b0;
    model_host(a, d, be);
  endtask

  task automatic cb_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cb_wr = 1'b1; cb_addr = a; cb_wdata = d;
    @(negedge clk);
    cb_wr = 1'b0;
    if (a == 2'd0) m_ctrl = d & 8'h49;
    if (a == 2'd3 && d[0]) m_pend = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    cb_addr = a; #1; v = cb_rdata;
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    rd(2'd0, v); chk({req, " ctrl"}, v, m_ctrl);
    rd(2'd1, v); chk({req, " p80"}, v, m_p80);
    rd(2'd2, v); chk({req, " p81"}, v, m_p81);
    rd(2'd3, v); chk({req, " stat"}, v, {7'd0, m_pend});
    chk({req, " irq R10"}, {7'd0, irq}, {7'd0, m_pend & m_ctrl[0]});
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    m_ctrl = 0; m_p80 = 0; m_p81 = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check_all("R1");
    chk("R1 ready", {7'd0, hw_ready}, 8'd1);

    // R2: only bits 0,3,6 stick
    cb_write(2'd0, 8'hFF); check_all("R2");
    cb_write(2'd0, 8'h00); check_all("R2");

    // R3: disabled ports ignore data
    host_wr(16'h0080, 16'hBEEF, 2'b11); check_all("R3");

    // R4: 16-bit write, both enabled
    cb_write(2'd0, 8'h49);
    host_wr(16'h0080, 16'h1234, 2'b11); check_all("R4");
    // R8: write 0 keeps, write 1 clears
    cb_write(2'd3, 8'hFE); check_all("R8");
    cb_write(2'd3, 8'h01); check_all("R8");
    // R5: single byte at 0x80
    host_wr(16'h0080, 16'hAA56, 2'b01); check_all("R5");
    cb_write(2'd3, 8'h01);
    // R6: single byte at 0x81
    host_wr(16'h0081, 16'h0077, 2'b01); check_all("R6");
    // R11: data registers read-only
    cb_write(2'd1, 8'h99); cb_write(2'd2, 8'h88); check_all("R11");
    // R3: only 0x80 enabled, 16-bit write must leave 0x81 alone
    cb_write(2'd3, 8'h01); cb_write(2'd0, 8'h41);
    host_wr(16'h0080, 16'hC3A5, 2'b11); check_all("R3");
    // R3/R7: only 0x81 enabled, byte to 0x80 sets nothing
    cb_write(2'd3, 8'h01); cb_write(2'd0, 8'h09);
    host_wr(16'h0080, 16'h0011, 2'b01); check_all("R7");
    // R12: lane 1 spills to 0x82, lane from 0x7F lands on 0x80
    cb_write(2'd0, 8'h49);
    host_wr(16'h0081, 16'h5500, 2'b10); check_all("R12");
    host_wr(16'h007F, 16'h6600, 2'b10); check_all("R12");
    // R10: irq follows enable without new capture
    cb_write(2'd0, 8'h48); check_all("R10");
    cb_write(2'd0, 8'h49); check_all("R10");
    // R9: capture and clear in the same cycle
    @(negedge clk);
    hw_valid = 1'b1; hw_addr = 16'h0080; hw_data = 16'h00E1; hw_be = 2'b01;
    cb_wr = 1'b1; cb_addr = 2'd3; cb_wdata = 8'h01;
    @(negedge clk);
    hw_valid = 1'b0; cb_wr = 1'b0;
    m_pend = 1'b0; model_host(16'h0080, 16'h00E1, 2'b01);
    check_all("R9");
    // R13: idle valid holds data
    hw_addr = 16'h0080; hw_data = 16'hFFFF; hw_be = 2'b11;
    repeat (3) @(negedge clk);
    check_all("R13");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] a;
      sel = $urandom_range(0, 9);
      if (sel < 5) begin
        case ($urandom_range(0, 4))
          0: a = 16'h007F;
          1: a = 16'h0080;
          2: a = 16'h0081;
          3: a = 16'h0082;
          default: a = 16'($urandom);
        endcase
        host_wr(a, 16'($urandom), 2'($urandom));
      end else if (sel < 7) begin
        cb_write(2'd0, 8'($urandom));
      end else begin
        cb_write(2'($urandom), 8'($urandom));
      end
      check_all("R13 rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule